// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block sits between an on-chip requester and a pipelined synchronous burst SRAM with a 32-bit data bus. The requester hands over a starting word address, a direction and a word count from 1 to 16. The controller then moves one word per clock. It lets the memory's own 2-bit linear burst counter supply the low address bits, and it drives chip enable, address strobe, output enable, write enable, byte enables and the word address from registers.

The memory's counter only steps the two lowest word-address bits and wraps from 3 back to 0. A linear burst that crosses a 4-word boundary would therefore fold back inside the same group. To prevent this, the controller issues a fresh address strobe with the full address on every word whose two low address bits are zero. The first word of a burst is always strobed.

Read data comes back through a delay line that matches the memory's two-cycle pipeline. Every burst closes with one deselect cycle, and a single-cycle done pulse marks the end of the transaction. The request side is a valid/ready handshake. The two data streams have no back-pressure: the controller pulls write words with `wr_ready` and must find data present, and it pushes read words with `rd_valid`, which the consumer must take in that cycle.

Top module: `sbsram_burst_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_len_m1` holds the word count minus one (0 means 1 word, 15 means 16 words), and exactly that many words are transferred.
- R2: Word i of a burst carries word address start+i on `sram_addr`. The first word is on the pins in the second cycle after the accepting edge. Consecutive burst words occupy consecutive cycles with `sram_ce_n` low.
- R3: `sram_ads_n` is low for the first word and for every later word whose address has its two low bits equal to 00. For all other burst words it is high, so the memory advances its counter. A burst therefore issues one strobe plus one per 4-word boundary crossed.
- R4: The memory registers a word at the end of its address cycle t and presents it two cycles later. The controller samples it and shows it on `rd_data` with `rd_valid` high for one cycle in cycle t+3. Words are delivered in address order.
- R5: `sram_oe_n` is low from the first read word's address cycle through the cycle in which the last read word is on `sram_dq_in`. It is high during write bursts and while idle.
- R6: During a write burst, `wr_ready` is high for one cycle per word. `wr_data` and `wr_strb` present in that cycle appear on the pins in the next cycle, with `sram_we_n` low, `sram_dq_oe` high and `sram_be_n = ~wr_strb`. The first data word shares its cycle with the first strobe. Only lanes whose `wr_strb` bit is 1 are changed in memory.
- R7: After the last word of any burst, exactly one deselect cycle follows, with `sram_ads_n` low and `sram_ce_n` high. The bus is idle in the cycle after it.
- R8: `done` is high for exactly one cycle, after the last read word has been delivered or after the write deselect cycle. `req_ready` is low during `done` and high in the cycle after it.
- R9: After reset, `req_ready` is high, all memory strobes and enables are high, `sram_dq_oe` is low, and `rd_valid` and `done` are low.
- R10: For read words, `sram_be_n` is driven all zero, so all four byte lanes are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the memory |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | AW | Starting word address |
| req_len_m1 | input | LEN_W | Word count minus one |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| wr_ready | output | 1 | Pull strobe for the next write word |
| wr_data | input | DW | Write word, valid whenever `wr_ready` is high |
| wr_strb | input | DW/8 | Byte lanes to write, active high |
| rd_valid | output | 1 | Read word present on `rd_data` |
| rd_data | output | DW | Read word |
| done | output | 1 | One-cycle end-of-transaction pulse |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_ads_n | output | 1 | Address strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | DW/8 | Byte enables, active low |
| sram_addr | output | AW | Word address |
| sram_dq_out | output | DW | Write data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | DW | Read data from the memory |

## Verification
The checker watches the pins on every cycle. It flags any counter advance (`sram_ce_n` low, `sram_ads_n` high) that lands on a 4-word boundary or that does not step the address by one from a selected cycle. It also flags write cycles that lack data drive or that collide with output enable, deselects that are not followed by an idle bus, and read word cycles without all byte enables. It further checks the idle pin state behind `req_ready`, the single-cycle `done` and the rule that a delivered read word was sampled under output enable. Some properties depend on contents and on counts across a whole burst, and only the bench scenarios can show them. These are that the memory's own counter really reaches the right words, that partial byte lanes survive, that the strobe count matches the boundaries crossed, and that the first read word arrives exactly three cycles after its address.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DESEL,
    ST_WAIT,
    ST_FIN
  } seq_state_t;

endpackage

// File: rtl/sbsram_seq.sv
module sbsram_seq
  import sbsram_pkg::*;
#(
  parameter int AW       = 20,
  parameter int LEN_W    = 4,
  parameter int CNT_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len_m1,
  input  logic             req_write,
  input  logic             rd_fin,
  output logic             req_ready,
  output logic             word_go,
  output logic             word_strobe,
  output logic             word_last,
  output logic             desel_go,
  output logic             op_write,
  output logic             done,
  output logic [AW-1:0]    word_addr
);

  seq_state_t       state_q;
  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] left_q;
  logic             wr_q;
  logic             first_q;

  // one word per cycle in ST_ISSUE; the memory counter only covers CNT_BITS
  assign req_ready   = (state_q == ST_IDLE);
  assign word_go     = (state_q == ST_ISSUE);
  assign desel_go    = (state_q == ST_DESEL);
  assign done        = (state_q == ST_FIN);
  assign word_addr   = addr_q;
  assign word_last   = (left_q == '0);
  assign word_strobe = first_q || (addr_q[CNT_BITS-1:0] == '0);
  assign op_write    = wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      first_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            left_q  <= req_len_m1;
            wr_q    <= req_write;
            first_q <= 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          addr_q  <= addr_q + 1'b1;
          first_q <= 1'b0;
          if (left_q == '0) state_q <= ST_DESEL;
          else              left_q  <= left_q - 1'b1;
        end
        ST_DESEL: state_q <= wr_q ? ST_FIN : ST_WAIT;
        ST_WAIT:  if (rd_fin) state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbsram_pins.sv
module sbsram_pins #(
  parameter int AW   = 20,
  parameter int DW   = 32,
  parameter int BE_W = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_go,
  input  logic            word_strobe,
  input  logic            word_last,
  input  logic            desel_go,
  input  logic            op_write,
  input  logic [AW-1:0]   word_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [BE_W-1:0] wr_strb,
  input  logic            cap_last,
  output logic            sram_ce_n,
  output logic            sram_ads_n,
  output logic            sram_oe_n,
  output logic            sram_we_n,
  output logic [BE_W-1:0] sram_be_n,
  output logic [AW-1:0]   sram_addr,
  output logic [DW-1:0]   sram_dq_out,
  output logic            sram_dq_oe,
  output logic            issue_rd,
  output logic            issue_last
);

  logic wr_word;
  assign wr_word = word_go && op_write;

  // command pins: idle by default, one word or one deselect per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n  <= 1'b1;
      sram_ads_n <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_be_n  <= '1;
      sram_dq_oe <= 1'b0;
      sram_addr  <= '0;
      issue_rd   <= 1'b0;
      issue_last <= 1'b0;
    end else begin
      sram_ce_n  <= 1'b1;
      sram_ads_n <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_be_n  <= '1;
      sram_dq_oe <= 1'b0;
      issue_rd   <= 1'b0;
      issue_last <= 1'b0;
      if (word_go) begin
        sram_ce_n  <= 1'b0;
        sram_ads_n <= !word_strobe;
        sram_addr  <= word_addr;
        sram_we_n  <= !op_write;
        sram_dq_oe <= op_write;
        sram_be_n  <= op_write ? ~wr_strb : '0;
        issue_rd   <= !op_write;
        issue_last <= word_last;
      end else if (desel_go) begin
        sram_ads_n <= 1'b0;
      end
    end
  end

  // output enable spans the read burst until the final word is sampled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sram_oe_n <= 1'b1;
    else if (word_go && !op_write) sram_oe_n <= 1'b0;
    else if (cap_last)             sram_oe_n <= 1'b1;
  end

  // write data path, one register per byte lane; disabled lanes hold
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       lane_q <= '0;
      else if (wr_word && wr_strb[g])   lane_q <= wr_data[8*g +: 8];
    end
    assign sram_dq_out[8*g +: 8] = lane_q;
  end

endmodule

// File: rtl/sbsram_rdalign.sv
module sbsram_rdalign #(
  parameter int DW     = 32,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_rd,
  input  logic          issue_last,
  input  logic [DW-1:0] sram_dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          cap_last,
  output logic          rd_fin
);

  logic [RD_LAT:0] pv;
  logic [RD_LAT:0] pl;
  logic            rd_last_q;

  assign pv[0] = issue_rd;
  assign pl[0] = issue_last;

  // delay line matching the memory pipeline, stage 0 aligned with the pins
  for (genvar s = 1; s <= RD_LAT; s++) begin : g_stage
    logic v_q, l_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        l_q <= 1'b0;
      end else begin
        v_q <= pv[s-1];
        l_q <= pl[s-1];
      end
    end
    assign pv[s] = v_q;
    assign pl[s] = l_q;
  end

  assign cap_last = pv[RD_LAT] && pl[RD_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_last_q <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid  <= pv[RD_LAT];
      rd_last_q <= cap_last;
      if (pv[RD_LAT]) rd_data <= sram_dq_in;
    end
  end

  assign rd_fin = rd_valid && rd_last_q;

endmodule

// File: rtl/sbsram_burst_ctrl.sv
module sbsram_burst_ctrl #(
  parameter int AW       = 20,
  parameter int DW       = 32,
  parameter int MAX_LEN  = 16,
  parameter int RD_LAT   = 2,
  parameter int CNT_BITS = 2,
  localparam int LEN_W   = $clog2(MAX_LEN),
  localparam int BE_W    = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len_m1,
  input  logic             req_write,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  input  logic [BE_W-1:0]  wr_strb,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             done,
  output logic             sram_ce_n,
  output logic             sram_ads_n,
  output logic             sram_oe_n,
  output logic             sram_we_n,
  output logic [BE_W-1:0]  sram_be_n,
  output logic [AW-1:0]    sram_addr,
  output logic [DW-1:0]    sram_dq_out,
  output logic             sram_dq_oe,
  input  logic [DW-1:0]    sram_dq_in
);

  logic          word_go, word_strobe, word_last, desel_go, op_write;
  logic [AW-1:0] word_addr;
  logic          issue_rd, issue_last, cap_last, rd_fin;

  assign wr_ready = word_go && op_write;

  sbsram_seq #(.AW(AW), .LEN_W(LEN_W), .CNT_BITS(CNT_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_len_m1 (req_len_m1),
    .req_write  (req_write),
    .rd_fin     (rd_fin),
    .req_ready  (req_ready),
    .word_go    (word_go),
    .word_strobe(word_strobe),
    .word_last  (word_last),
    .desel_go   (desel_go),
    .op_write   (op_write),
    .done       (done),
    .word_addr  (word_addr)
  );

  sbsram_pins #(.AW(AW), .DW(DW), .BE_W(BE_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_go    (word_go),
    .word_strobe(word_strobe),
    .word_last  (word_last),
    .desel_go   (desel_go),
    .op_write   (op_write),
    .word_addr  (word_addr),
    .wr_data    (wr_data),
    .wr_strb    (wr_strb),
    .cap_last   (cap_last),
    .sram_ce_n  (sram_ce_n),
    .sram_ads_n (sram_ads_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_be_n  (sram_be_n),
    .sram_addr  (sram_addr),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe),
    .issue_rd   (issue_rd),
    .issue_last (issue_last)
  );

  sbsram_rdalign #(.DW(DW), .RD_LAT(RD_LAT)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_rd  (issue_rd),
    .issue_last(issue_last),
    .sram_dq_in(sram_dq_in),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .cap_last  (cap_last),
    .rd_fin    (rd_fin)
  );

endmodule

// File: rtl/sbsram_burst_chk.sv
module sbsram_burst_chk #(
  parameter int AW       = 20,
  parameter int BE_W     = 4,
  parameter int CNT_BITS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            done,
  input logic            rd_valid,
  input logic            sram_ce_n,
  input logic            sram_ads_n,
  input logic            sram_oe_n,
  input logic            sram_we_n,
  input logic [BE_W-1:0] sram_be_n,
  input logic [AW-1:0]   sram_addr,
  input logic            sram_dq_oe
);

  // R3
  no_wrap_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && sram_ads_n) |-> (sram_addr[CNT_BITS-1:0] != '0));

  // R2
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && sram_ads_n) |-> (!$past(sram_ce_n) && sram_addr == $past(sram_addr) + 1'b1));

  // R6
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_dq_oe && sram_oe_n));

  // R7
  deselect_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ads_n && sram_ce_n) |=> (sram_ads_n && sram_ce_n));

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_ads_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R4
  read_under_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(sram_oe_n));

  // R10
  read_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && sram_we_n) |-> (sram_be_n == '0));

endmodule

bind sbsram_burst_ctrl sbsram_burst_chk #(.AW(AW), .BE_W(BE_W), .CNT_BITS(CNT_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .rd_valid  (rd_valid),
  .sram_ce_n (sram_ce_n),
  .sram_ads_n(sram_ads_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .sram_be_n (sram_be_n),
  .sram_addr (sram_addr),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_sbsram_burst_ctrl.sv
module sim_sbsram_burst_ctrl;

  localparam int AW = 20;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_len_m1 = '0;
  logic          req_write = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic [3:0]    wr_strb = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          done;
  logic          sram_ce_n, sram_ads_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [3:0]    sram_be_n;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq_out;
  logic [DW-1:0] sram_dq_in = '0;

  always #5 clk = ~clk;

  sbsram_burst_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len_m1(req_len_m1), .req_write(req_write),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .sram_ce_n(sram_ce_n), .sram_ads_n(sram_ads_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;

  logic [DW-1:0] mem  [256];
  logic [DW-1:0] gold [256];
  logic [DW-1:0] exp_q [$];
  logic [DW+3:0] wq [$];

  int strb_cnt, desel_cnt, first_pin, first_rv;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [3:0] be_n);
    logic [DW-1:0] r = old;
    for (int b = 0; b < 4; b++) if (!be_n[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // pipelined burst memory model: 2-bit linear counter, two-cycle read latency
  logic          m_act = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_v = 1'b0;
  logic          dq_v = 1'b0;

  always @(posedge clk) begin
    logic [AW-1:0] cur;
    logic          go;
    go  = 1'b0;
    cur = m_addr;
    if (!rst_n) begin
      m_act <= 1'b0;
      st_v  <= 1'b0;
      dq_v  <= 1'b0;
    end else begin
      if (!sram_ads_n) begin
        if (!sram_ce_n) begin
          go = 1'b1;
          cur = sram_addr;
          m_act <= 1'b1;
        end else m_act <= 1'b0;
      end else if (m_act) begin
        go = 1'b1;
        cur = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
      end
      m_addr <= cur;
      st_v <= 1'b0;
      if (go) begin
        if (!sram_we_n) mem[cur[7:0]] <= merge(mem[cur[7:0]], sram_dq_out, sram_be_n);
        else begin
          st_data <= mem[cur[7:0]];
          st_v    <= 1'b1;
        end
      end
      sram_dq_in <= st_data;
      dq_v       <= st_v;
    end
  end

  // write feeder: data must be present in the cycle wr_ready is high
  always @(negedge clk) begin
    if (rst_n && wr_ready) begin
      if (wq.size() == 0) chk(1'b0, "R6", "write pull with empty source", 64'd1, 64'd0);
      else {wr_data, wr_strb} = wq.pop_front();
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R1", "extra read word", 64'(rd_data), 64'd0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R4", "read data", 64'(rd_data), 64'(e));
          if (first_rv < 0) first_rv = cyc;
        end
      end
      if (!sram_ads_n && !sram_ce_n) begin
        strb_cnt++;
        if (first_pin < 0) first_pin = cyc;
      end
      if (!sram_ads_n && sram_ce_n) desel_cnt++;
      if (dq_v) chk(!sram_oe_n, "R5", "oe during memory read output", 64'(sram_oe_n), 64'd0);
      if (!sram_ce_n && sram_we_n) begin
        chk(!sram_oe_n, "R5", "oe on read word", 64'(sram_oe_n), 64'd0);
        chk(sram_be_n == 4'h0, "R10", "read byte enables", 64'(sram_be_n), 64'd0);
      end
      if (!sram_ce_n && !sram_we_n)
        chk(sram_oe_n, "R5", "oe on write word", 64'(sram_oe_n), 64'd1);
    end
  end

  function automatic int exp_strobes(input int a, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (i == 0 || ((a + i) % 4) == 0) c++;
    return c;
  endfunction

  task automatic run_burst(input bit wr, input int a, input int n, input logic [3:0] strb);
    int hs;
    for (int i = 0; i < n; i++) begin
      int w;
      w = (a + i) & 255;
      if (wr) begin
        logic [DW-1:0] d;
        d = 32'hC0DE0000 ^ 32'(a * 131 + i * 7 + cyc);
        wq.push_back({d, strb});
        gold[w] = merge(gold[w], d, ~strb);
      end else exp_q.push_back(gold[w]);
    end
    strb_cnt = 0; desel_cnt = 0; first_pin = -1; first_rv = -1;
    @(negedge clk);
    req_addr = AW'(a); req_len_m1 = 4'(n - 1); req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    hs = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "ready while busy", 64'(req_ready), 64'd0);
    while (!done) @(negedge clk);
    chk(exp_q.size() == 0 && wq.size() == 0, "R8", "words left at done",
        64'(exp_q.size() + wq.size()), 64'd0);
    chk(!req_ready, "R8", "ready during done", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(!done && req_ready, "R8", "after done {done,ready}", 64'({done, req_ready}), 64'b01);
    chk(strb_cnt == exp_strobes(a, n), "R3", "strobe count", 64'(strb_cnt), 64'(exp_strobes(a, n)));
    chk(desel_cnt == 1, "R7", "deselect count", 64'(desel_cnt), 64'd1);
    chk(first_pin == hs + 1, "R2", "first address cycle", 64'(first_pin), 64'(hs + 1));
    if (!wr) chk(first_rv == first_pin + 3, "R4", "first read latency", 64'(first_rv), 64'(first_pin + 3));
    else for (int i = 0; i < n; i++)
      chk(mem[(a + i) & 255] == gold[(a + i) & 255], "R6", "memory after write",
          64'(mem[(a + i) & 255]), 64'(gold[(a + i) & 255]));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 32'h5A5A0000 | 32'(i * 3);
      gold[i] = 32'h5A5A0000 | 32'(i * 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(req_ready, "R9", "ready after reset", 64'(req_ready), 64'd1);
    chk({sram_ce_n, sram_ads_n, sram_oe_n, sram_we_n} == 4'hF, "R9", "strobes after reset",
        64'({sram_ce_n, sram_ads_n, sram_oe_n, sram_we_n}), 64'hF);
    chk(!sram_dq_oe && !rd_valid && !done, "R9", "drive/valid/done after reset",
        64'({sram_dq_oe, rd_valid, done}), 64'd0);
    mon_en = 1'b1;
    run_burst(1'b1, 'h07, 16, 4'hF);  // R3 crossings, R6
    run_burst(1'b0, 'h02, 6, 4'hF);   // R3 strobes at 2 and 4
    run_burst(1'b0, 'h07, 16, 4'hF);  // R4 read back
    run_burst(1'b0, 'h03, 1, 4'hF);   // R1 single word
    run_burst(1'b1, 'h20, 4, 4'h5);   // R6 partial lanes
    run_burst(1'b0, 'h20, 4, 4'hF);
    run_burst(1'b0, 'h1F, 5, 4'hF);
    run_burst(1'b1, 'h30, 1, 4'hA);
    run_burst(1'b0, 'h2F, 3, 4'hF);
    run_burst(1'b0, 'h00, 16, 4'hF);
    run_burst(1'b1, 'h03, 2, 4'hF);
    run_burst(1'b0, 'h03, 2, 4'hF);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule